// File: doc/BRIEF.md
# Key-Protected Watchdog Timer

This block is a watchdog timer on a simple 32-bit register bus. It has one write port and one combinational read port. A 31-bit counter advances one step per clock while it is running. A view of the counter, shifted right by a 3-bit power-of-two prescale setting and cut to 16 bits, is compared against a 16-bit threshold. When the scaled value reaches or passes the threshold, a sticky pending flag is set and drives the interrupt line. Two optional behaviours can be enabled on a match: the counter can restart from zero, which gives a periodic tick, and a system reset request can be raised.

Every write to a control register has effect only when the bus write just before it stored the unlock word in the key register. Each unlock covers exactly one write. A "pet" clears the counter, and it is accepted only when it carries a fixed magic value. The counter has three run modes: stopped, always running, and running only while the core reports that it is awake.

Top module: `kwdt_top`

## Requirements
- R1: After reset the control register reads 0, the threshold reads 0xFFFF, the raw counter reads 0, the key register reads 0 (locked), and `irq_o` and `rst_req_o` are low.
- R2: While the counter runs, the raw counter at offset 0x08 rises by one per clock. The scaled counter at offset 0x10 equals the raw counter shifted right by control bits [2:0], truncated to 16 bits.
- R3: While control bit 8 is set and a match holds, `rst_req_o` is high. Otherwise it is low.
- R4: When control bit 9 is set, a match clears the counter to zero at the next clock, so the count repeats periodically.
- R5: Control bit 12 makes the counter run on every clock. Control bit 13 makes it run only on clocks where `awake_i` is high. With both bits clear, the counter holds its value.
- R6: A match means scaled counter >= threshold, so a threshold of 0 matches at once. A match sets control bit 28, which is sticky and drives `irq_o`. An accepted control write with bit 28 at 0 clears it, unless a match holds in that same cycle, in which case the match wins.
- R7: Writing 0x0051F15E to offset 0x1C arms the block for one write. Writes to offsets 0x00 (control), 0x18 (pet) and 0x20 (threshold) have effect only when the block is armed.
- R8: An armed write of 0x0D09F00D to offset 0x18 clears the counter at that clock. An armed write of any other value to 0x18 changes nothing except that it disarms the block.
- R9: Any bus write other than the unlock word to 0x1C leaves the block disarmed after it. Bit 0 of offset 0x1C reads 1 while the block is armed.
- R10: Reads need no unlock. Offset 0x00 returns control bits 28, 13, 12, 9, 8 and [2:0]. Offset 0x08 returns the raw counter with bit 31 at 0. Offset 0x10 returns the scaled counter. Offset 0x20 returns the threshold in [15:0]. Offset 0x18 and unmapped offsets return 0.
- R11: A write to the read-only counter offsets, or to an unmapped offset, changes no state but still uses up a pending unlock.
- R12: A threshold write keeps only bits [15:0] of the written data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe, one write per cycle |
| wr_addr | input | 6 | Byte offset of the write |
| wr_data | input | 32 | Write data |
| rd_addr | input | 6 | Byte offset of the combinational read |
| rd_data | output | 32 | Read data |
| awake_i | input | 1 | Core-awake indication used by the awake-only run mode |
| irq_o | output | 1 | Interrupt, equal to the pending flag |
| rst_req_o | output | 1 | System reset request |

## Verification
The bench builds the block with its default parameters: a 31-bit counter, a 16-bit threshold and the fixed unlock and pet words. Because the threshold is programmable, small values such as 0 and 4 make a match, the periodic restart and the reset request reachable within a few dozen clocks. With prescale 2, the right shift of the scaled view shows up clearly. A behavioural model tracks the lock, the counter, the configuration and the pending flag on every clock. Directed steps cover stray writes, wrong pet values, writes to read-only offsets and the case where a match and a clearing write fall in the same cycle.

// File: rtl/kwdt_pkg.sv
package kwdt_pkg;

    localparam int SCALE_W = 3;

    // byte offsets of the register window
    localparam int OFF_CTRL   = 'h00;
    localparam int OFF_RAW    = 'h08;
    localparam int OFF_SCALED = 'h10;
    localparam int OFF_PET    = 'h18;
    localparam int OFF_KEY    = 'h1C;
    localparam int OFF_THR    = 'h20;

    // control bit positions
    localparam int B_RSTEN  = 8;
    localparam int B_ZERO   = 9;
    localparam int B_ALWAYS = 12;
    localparam int B_AWAKE  = 13;
    localparam int B_PEND   = 28;

    typedef struct packed {
        logic               pend;
        logic               run_awake;
        logic               run_always;
        logic               zero_cmp;
        logic               rst_en;
        logic [SCALE_W-1:0] scale;
    } ctrl_t;

    function automatic logic [31:0] ctrl_to_word(ctrl_t c);
        logic [31:0] w;
        w            = '0;
        w[SCALE_W-1:0] = c.scale;
        w[B_RSTEN]   = c.rst_en;
        w[B_ZERO]    = c.zero_cmp;
        w[B_ALWAYS]  = c.run_always;
        w[B_AWAKE]   = c.run_awake;
        w[B_PEND]    = c.pend;
        return w;
    endfunction

endpackage

// File: rtl/kwdt_unlock.sv
module kwdt_unlock #(
    parameter int          ADDR_W  = 6,
    parameter logic [31:0] KEY_VAL = 32'h0051F15E
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [31:0]       wr_data,
    output logic              armed_o
);
    import kwdt_pkg::*;

    typedef struct packed {
        logic armed;
    } lock_st_t;

    lock_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.armed = (wr_addr == ADDR_W'(OFF_KEY)) && (wr_data == KEY_VAL);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign armed_o = st_q.armed;
endmodule

// File: rtl/kwdt_regs.sv
module kwdt_regs #(
    parameter int          ADDR_W   = 6,
    parameter int          CMP_W    = 16,
    parameter logic [31:0] PET_VAL  = 32'h0D09F00D,
    parameter logic [CMP_W-1:0] THR_RST = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ok,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [31:0]       wr_data,
    input  logic              match_i,
    output kwdt_pkg::ctrl_t   ctrl_o,
    output logic [CMP_W-1:0]  thr_o,
    output logic              pet_o
);
    import kwdt_pkg::*;

    typedef struct packed {
        ctrl_t            ctrl;
        logic [CMP_W-1:0] thr;
    } reg_st_t;

    reg_st_t st_d, st_q;
    logic    wr_ctrl, wr_thr;

    always_comb begin
        wr_ctrl = wr_ok && (wr_addr == ADDR_W'(OFF_CTRL));
        wr_thr  = wr_ok && (wr_addr == ADDR_W'(OFF_THR));
        pet_o   = wr_ok && (wr_addr == ADDR_W'(OFF_PET)) && (wr_data == PET_VAL);

        st_d = st_q;
        if (wr_ctrl) begin
            st_d.ctrl.scale      = wr_data[SCALE_W-1:0];
            st_d.ctrl.rst_en     = wr_data[B_RSTEN];
            st_d.ctrl.zero_cmp   = wr_data[B_ZERO];
            st_d.ctrl.run_always = wr_data[B_ALWAYS];
            st_d.ctrl.run_awake  = wr_data[B_AWAKE];
            st_d.ctrl.pend       = wr_data[B_PEND];
        end
        if (match_i) st_d.ctrl.pend = 1'b1;
        if (wr_thr)  st_d.thr = wr_data[CMP_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.ctrl <= '0;
            st_q.thr  <= THR_RST;
        end else begin
            st_q <= st_d;
        end
    end

    assign ctrl_o = st_q.ctrl;
    assign thr_o  = st_q.thr;
endmodule

// File: rtl/kwdt_counter.sv
module kwdt_counter #(
    parameter int CNT_W = 31,
    parameter int CMP_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  kwdt_pkg::ctrl_t  ctrl_i,
    input  logic             awake_i,
    input  logic             pet_i,
    input  logic [CMP_W-1:0] thr_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CMP_W-1:0] scaled_o,
    output logic             match_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_st_t;

    cnt_st_t          st_d, st_q;
    logic             run;
    logic [CNT_W-1:0] shifted;

    always_comb begin
        shifted  = st_q.cnt >> ctrl_i.scale;
        scaled_o = shifted[CMP_W-1:0];
        match_o  = (scaled_o >= thr_i);
        run      = ctrl_i.run_always || (ctrl_i.run_awake && awake_i);

        st_d = st_q;
        if (pet_i)                         st_d.cnt = '0;
        else if (match_o && ctrl_i.zero_cmp) st_d.cnt = '0;
        else if (run)                      st_d.cnt = st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt_o = st_q.cnt;
endmodule

// File: rtl/kwdt_top.sv
module kwdt_top #(
    parameter int          ADDR_W   = 6,
    parameter int          CNT_W    = 31,
    parameter int          CMP_W    = 16,
    parameter logic [31:0] KEY_VAL  = 32'h0051F15E,
    parameter logic [31:0] PET_VAL  = 32'h0D09F00D
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [31:0]       wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [31:0]       rd_data,
    input  logic              awake_i,
    output logic              irq_o,
    output logic              rst_req_o
);
    import kwdt_pkg::*;

    logic             armed, wr_ok, pet, match;
    ctrl_t            ctrl;
    logic [CMP_W-1:0] thr, scaled;
    logic [CNT_W-1:0] cnt;

    assign wr_ok = wr_en && armed;

    kwdt_unlock #(.ADDR_W(ADDR_W), .KEY_VAL(KEY_VAL)) u_lock (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .armed_o(armed)
    );

    kwdt_regs #(.ADDR_W(ADDR_W), .CMP_W(CMP_W), .PET_VAL(PET_VAL)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_ok(wr_ok), .wr_addr(wr_addr),
        .wr_data(wr_data), .match_i(match), .ctrl_o(ctrl), .thr_o(thr),
        .pet_o(pet)
    );

    kwdt_counter #(.CNT_W(CNT_W), .CMP_W(CMP_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .ctrl_i(ctrl), .awake_i(awake_i),
        .pet_i(pet), .thr_i(thr), .cnt_o(cnt), .scaled_o(scaled),
        .match_o(match)
    );

    always_comb begin
        rd_data = '0;
        case (rd_addr)
            ADDR_W'(OFF_CTRL):   rd_data = ctrl_to_word(ctrl);
            ADDR_W'(OFF_RAW):    rd_data = 32'(cnt);
            ADDR_W'(OFF_SCALED): rd_data = 32'(scaled);
            ADDR_W'(OFF_KEY):    rd_data = {31'd0, armed};
            ADDR_W'(OFF_THR):    rd_data = 32'(thr);
            default:             rd_data = '0;
        endcase
    end

    assign irq_o     = ctrl.pend;
    assign rst_req_o = ctrl.rst_en && match;
endmodule

// File: rtl/kwdt_chk.sv
module kwdt_chk #(
    parameter int          ADDR_W  = 6,
    parameter int          CNT_W   = 31,
    parameter int          CMP_W   = 16,
    parameter logic [31:0] KEY_VAL = 32'h0051F15E
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [31:0]       wr_data,
    input logic              armed,
    input logic [CMP_W-1:0]  thr,
    input logic [CNT_W-1:0]  cnt,
    input logic              match,
    input logic              pet,
    input logic              zero_cmp,
    input logic              irq_o,
    input logic              rst_req_o
);
    import kwdt_pkg::*;

    // R7
    thr_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !armed) |=> $stable(thr));

    // R9
    disarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !((wr_addr == ADDR_W'(OFF_KEY)) && (wr_data == KEY_VAL))) |=> !armed);

    // R6
    pend_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && !(wr_en && armed && (wr_addr == ADDR_W'(OFF_CTRL)))) |=> irq_o);

    // R4
    zero_on_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (match && zero_cmp && !pet) |=> (cnt == '0));

    // R8
    pet_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pet |=> (cnt == '0));

    // R3
    rst_req_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req_o |=> irq_o);
endmodule

bind kwdt_top kwdt_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .CMP_W(CMP_W), .KEY_VAL(KEY_VAL)) chk_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .armed(armed), .thr(thr), .cnt(cnt), .match(match), .pet(pet),
    .zero_cmp(ctrl.zero_cmp), .irq_o(irq_o), .rst_req_o(rst_req_o)
);

// File: tb/kwdt_top_tb_top.sv
module kwdt_top_tb_top;
    localparam logic [31:0] KEY = 32'h0051F15E;
    localparam logic [31:0] PET = 32'h0D09F00D;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [5:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [5:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        awake_i = 1'b0;
    logic        irq_o, rst_req_o;

    int total = 0;
    int bad = 0;
    bit done = 0;

    kwdt_top dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .awake_i(awake_i), .irq_o(irq_o), .rst_req_o(rst_req_o)
    );

    always #5 clk = ~clk;

    // behavioural reference state
    logic [30:0] m_cnt;
    logic [2:0]  m_sc;
    logic        m_rsten, m_zc, m_al, m_aw, m_ip, m_lock;
    logic [15:0] m_thr;

    function automatic logic [15:0] m_scaled();
        logic [30:0] s;
        s = m_cnt >> m_sc;
        return s[15:0];
    endfunction

    function automatic logic m_match();
        return m_scaled() >= m_thr;
    endfunction

    function automatic logic [31:0] m_read(logic [5:0] a);
        case (a)
            6'h00: return {3'd0, m_ip, 14'd0, m_aw, m_al, 2'd0, m_zc, m_rsten, 5'd0, m_sc};
            6'h08: return {1'b0, m_cnt};
            6'h10: return {16'd0, m_scaled()};
            6'h1C: return {31'd0, m_lock};
            6'h20: return {16'd0, m_thr};
            default: return 32'd0;
        endcase
    endfunction

    task automatic m_reset();
        m_cnt = '0; m_sc = '0; m_rsten = 0; m_zc = 0; m_al = 0; m_aw = 0;
        m_ip = 0; m_lock = 0; m_thr = 16'hFFFF;
    endtask

    initial m_reset();

    always @(posedge clk) begin
        if (!rst_n) m_reset();
        else begin
            logic acc, mt;
            logic [30:0] ncnt;
            acc = wr_en && m_lock;
            mt  = m_match();
            if (acc && wr_addr == 6'h18 && wr_data == PET) ncnt = '0;
            else if (mt && m_zc) ncnt = '0;
            else if (m_al || (m_aw && awake_i)) ncnt = m_cnt + 31'd1;
            else ncnt = m_cnt;
            if (acc && wr_addr == 6'h00) begin
                m_sc = wr_data[2:0]; m_rsten = wr_data[8]; m_zc = wr_data[9];
                m_al = wr_data[12]; m_aw = wr_data[13]; m_ip = wr_data[28];
            end
            if (mt) m_ip = 1'b1;
            if (acc && wr_addr == 6'h20) m_thr = wr_data[15:0];
            if (wr_en) m_lock = (wr_addr == 6'h1C) && (wr_data == KEY);
            m_cnt = ncnt;
        end
    end

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    // per-clock comparison against the model
    always begin
        @(posedge clk);
        #2;
        if (rst_n && !done) begin
            chk("R6 irq model", {31'd0, irq_o}, {31'd0, m_ip});
            chk("R3 rst_req model", {31'd0, rst_req_o}, {31'd0, m_rsten && m_match()});
            chk("R10 read model", rd_data, m_read(rd_addr));
        end
    end

    task automatic wr(logic [5:0] a, logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic uwr(logic [5:0] a, logic [31:0] d);
        wr(6'h1C, KEY);
        wr(a, d);
    endtask

    task automatic rd(logic [5:0] a, logic [31:0] exp, string tag);
        rd_addr = a;
        #1;
        chk(tag, rd_data, exp);
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #1_000_000;
        total++; bad++;
        $display("FAIL watchdog expired act=running exp=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int zeros;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        rd(6'h00, 32'h0, "R1 ctrl");
        rd(6'h20, 32'hFFFF, "R1 thr");
        rd(6'h1C, 32'h0, "R1 key");
        rd(6'h08, 32'h0, "R1 raw");
        chk("R1 irq", {31'd0, irq_o}, 32'd0);
        chk("R1 rst_req", {31'd0, rst_req_o}, 32'd0);
        // R7 write without unlock dropped
        wr(6'h00, 32'h1000);
        rd(6'h00, 32'h0, "R7 locked ctrl");
        // R9 arm readback and single-use
        wr(6'h1C, KEY);
        rd(6'h1C, 32'h1, "R9 armed");
        wr(6'h00, 32'h1000);
        rd(6'h00, 32'h1000, "R7 armed ctrl");
        rd(6'h1C, 32'h0, "R9 consumed");
        // R8 pet clears, R2 counting
        uwr(6'h18, PET);
        rd(6'h08, 32'd0, "R8 pet clear");
        idle(5);
        rd(6'h08, 32'd5, "R2 raw count");
        uwr(6'h18, 32'h12345678);
        rd(6'h08, 32'd9, "R8 wrong pet ignored");
        rd(6'h1C, 32'h0, "R9 wrong pet disarms");
        // R2 prescale
        uwr(6'h18, PET);
        uwr(6'h00, 32'h1002);
        idle(8);
        rd(6'h08, 32'd12, "R2 raw scaled run");
        rd(6'h10, 32'd3, "R2 scaled");
        // R12 threshold width, R6 match
        uwr(6'h20, 32'hABCD0004);
        rd(6'h20, 32'h4, "R12 thr low bits");
        idle(2);
        chk("R6 irq on match", {31'd0, irq_o}, 32'd1);
        // R4 periodic zero
        uwr(6'h00, 32'h1202);
        zeros = 0;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            rd_addr = 6'h08; #1;
            if (rd_data == 32'd0) zeros++;
            chk("R4 bounded count", {31'd0, rd_data <= 32'd16}, 32'd1);
        end
        chk("R4 periodic restart", {31'd0, zeros >= 3}, 32'd1);
        // R6 clear pending
        uwr(6'h20, 32'hFFFF);
        uwr(6'h00, 32'h1000);
        chk("R6 irq cleared", {31'd0, irq_o}, 32'd0);
        rd(6'h00, 32'h1000, "R6 ctrl after clear");
        // R5 awake mode
        awake_i = 1'b0;
        uwr(6'h00, 32'h2000);
        uwr(6'h18, PET);
        idle(6);
        rd(6'h08, 32'd0, "R5 awake low holds");
        awake_i = 1'b1;
        idle(6);
        rd(6'h08, 32'd6, "R5 awake high runs");
        uwr(6'h00, 32'h0);
        idle(5);
        rd(6'h08, 32'd10, "R5 stopped holds");
        // R6 threshold zero, R3 reset request
        uwr(6'h20, 32'h0);
        idle(1);
        chk("R6 thr zero irq", {31'd0, irq_o}, 32'd1);
        chk("R3 rst_req off", {31'd0, rst_req_o}, 32'd0);
        uwr(6'h00, 32'h0100);
        chk("R3 rst_req on", {31'd0, rst_req_o}, 32'd1);
        uwr(6'h00, 32'h0);
        chk("R3 rst_req released", {31'd0, rst_req_o}, 32'd0);
        chk("R6 match beats clear", {31'd0, irq_o}, 32'd1);
        // R11 write to read-only offset consumes unlock
        uwr(6'h08, 32'hFFFF_FFFF);
        rd(6'h08, 32'd10, "R11 raw unchanged");
        wr(6'h00, 32'h1000);
        rd(6'h00, 32'h1000_0000, "R11 unlock consumed");
        rd(6'h04, 32'h0, "R10 unmapped");
        rd(6'h18, 32'h0, "R10 pet reads zero");
        idle(3);
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule